// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block fills a translation buffer after a miss. It takes the virtual page number of the access that missed. It then looks that page up in a two-level table held in physical memory. The upper ten bits of the page number select a word in the root table. The root table's physical address comes from a register that software reloads on every process switch. The lower ten bits then select a word in the second-level table that the root entry points at. Each lookup is one 32-bit read over a single request/response memory port. Only one read is outstanding at any time.

Every table entry carries a present flag, permission and usage flags, and a physical page number. If both entries are present, the block offers a refill to the translation buffer. The refill carries the page number it was asked for, the resolved physical page and the leaf's flags. If either entry is absent, the block offers a page fault instead and reports which level stopped the walk. The result is held until the consumer accepts it. The block handles one walk at a time and accepts a new one only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready` is 1 and `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: The first read of a walk goes to `root_base` + 4 × vpn[19:10]. `root_base` is sampled in the cycle the walk is accepted, so later changes to it do not affect that walk.
- R3: The second read goes to {root-entry bits 31:12, 12'h000} + 4 × vpn[9:0].
- R4: A root entry with bit 0 (present) clear ends the walk with `fault_valid`=1 and `fault_lvl`=0, and no second read is issued.
- R5: A leaf entry with bit 0 clear ends the walk with `fault_valid`=1 and `fault_lvl`=1.
- R6: A present leaf gives `fill_valid`=1 with `fill_ppn` = leaf bits 31:12 and `fill_perm` = leaf bits 4:1, which are read, write, user and dirty in that order from bit 1 upward. `res_vpn` equals the requested page number. `fill_valid` and `fault_valid` are never high together.
- R7: A read request stays valid with a stable address until `mem_req_ready` is high, and is dropped once it is accepted.
- R8: `fill_valid` or `fault_valid` and its data stay stable until `done_ready`. The block then returns to idle, with `walk_ready`=1 in the next cycle.
- R9: While `walk_ready` is 0, `walk_valid` and `walk_vpn` are ignored.
- R10: `mem_rsp_valid` is ignored when no read has been accepted and left unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid | input | 1 | Walk request |
| walk_ready | output | 1 | Walker idle, request accepted |
| walk_vpn | input | 20 | Virtual page number to translate |
| root_base | input | 32 | Physical address of the root table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical word address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_ready | input | 1 | Consumer accepts the refill or fault |
| fill_valid | output | 1 | Refill available |
| fault_valid | output | 1 | Page fault available |
| res_vpn | output | 20 | Page number of the finished walk |
| fill_ppn | output | 20 | Resolved physical page number |
| fill_perm | output | 4 | {dirty, user, write, read} |
| fault_lvl | output | 1 | 0: root entry absent, 1: leaf absent |

## Verification
The hardest case to reach from the ports is a stray response strobe. It has to arrive while a read request is still waiting for acceptance, or while the walker is idle or holding a result. A correct walker must ignore it, but a weak one would take the stray data as a table entry. The bench's memory model toggles `mem_req_ready` at random, adds a random delay to each reply, and injects stray strobes carrying an all-ones "present" word in the gaps. The bench also keeps `walk_valid` high with a different page number and moves `root_base` in the middle of walks. A reference model that advances each clock flags any of these leaking into an address or result.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   walk_valid,
  output logic                   walk_ready,
  input  logic [VA_W-OFF_W-1:0]  walk_vpn,
  input  logic [PA_W-1:0]        root_base,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  input  logic                   done_ready,
  output logic                   fill_valid,
  output logic                   fault_valid,
  output logic [VA_W-OFF_W-1:0]  res_vpn,
  output logic [PA_W-OFF_W-1:0]  fill_ppn,
  output logic [3:0]             fill_perm,
  output logic                   fault_lvl
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = VPN_W / 2;
  localparam int PPN_W = PA_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic             issued;
  logic [VPN_W-1:0] vpn_q;
  logic [PA_W-1:0]  tbl_q;
  logic [PPN_W-1:0] ppn_q;
  logic [3:0]       perm_q;
  logic             lvl_q;

  logic             reading;
  logic             rsp_take;
  logic [IDX_W-1:0] idx;

  assign reading  = (st == S_RD1) || (st == S_RD2);
  assign rsp_take = reading && issued && mem_rsp_valid;
  assign idx      = (st == S_RD1) ? vpn_q[VPN_W-1 -: IDX_W] : vpn_q[IDX_W-1:0];

  assign walk_ready    = (st == S_IDLE);
  assign mem_req_valid = reading && !issued;
  assign mem_req_addr  = tbl_q + PA_W'({idx, 2'b00});
  assign fill_valid    = (st == S_DONE);
  assign fault_valid   = (st == S_FAULT);
  assign res_vpn       = vpn_q;
  assign fill_ppn      = ppn_q;
  assign fill_perm     = perm_q;
  assign fault_lvl     = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      issued <= 1'b0;
      vpn_q  <= '0;
      tbl_q  <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (walk_valid) begin
          vpn_q  <= walk_vpn;
          tbl_q  <= root_base;
          issued <= 1'b0;
          st     <= S_RD1;
        end
        S_RD1, S_RD2: begin
          if (mem_req_valid && mem_req_ready) begin
            issued <= 1'b1;
          end else if (rsp_take) begin
            issued <= 1'b0;
            if (!mem_rsp_data[0]) begin
              lvl_q <= (st == S_RD2);
              st    <= S_FAULT;
            end else if (st == S_RD1) begin
              tbl_q <= {mem_rsp_data[PTE_W-1 -: PPN_W], {OFF_W{1'b0}}};
              st    <= S_RD2;
            end else begin
              ppn_q  <= mem_rsp_data[PTE_W-1 -: PPN_W];
              perm_q <= mem_rsp_data[4:1];
              st     <= S_DONE;
            end
          end
        end
        S_DONE, S_FAULT: if (done_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  assert_fill_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !done_ready |=> fill_valid && $stable(fill_ppn) && $stable(fill_perm) && $stable(res_vpn));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !done_ready |=> fault_valid && $stable(fault_lvl) && $stable(res_vpn));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid) && done_ready |=> walk_ready);

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_ready |=> $stable(res_vpn));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req_valid && !fill_valid && !fault_valid);
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam logic [31:0] ROOT  = 32'h1000_0000;
  localparam logic [31:0] ROOT2 = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [19:0] walk_vpn = '0;
  logic [31:0] root_base = ROOT;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_ready = 1'b0;
  logic        fill_valid, fault_valid, fault_lvl;
  logic [19:0] res_vpn, fill_ppn;
  logic [3:0]  fill_perm;

  always #2 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_ready(walk_ready),
    .walk_vpn(walk_vpn), .root_base(root_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_ready(done_ready), .fill_valid(fill_valid), .fault_valid(fault_valid),
    .res_vpn(res_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fault_lvl(fault_lvl)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit comparing = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] pte(input logic [19:0] ppn, input logic [3:0] perm, input bit p);
    return {ppn, 7'b0, perm, p};
  endfunction

  // reference model: phase 0 idle, 1 root read, 2 leaf read, 3 refill, 4 fault
  int          m_ph = 0;
  bit          m_sent = 0;
  logic [19:0] m_vpn = '0, m_ppn = '0;
  logic [31:0] m_root = '0, m_base = '0;
  logic [3:0]  m_perm = '0;
  bit          m_lvl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_sent <= 0;
    end else case (m_ph)
      0: if (walk_valid) begin m_vpn <= walk_vpn; m_root <= root_base; m_sent <= 0; m_ph <= 1; end
      1, 2: if (!m_sent) begin
              if (mem_req_ready) m_sent <= 1;
            end else if (mem_rsp_valid) begin
              m_sent <= 0;
              if (!mem_rsp_data[0]) begin m_lvl <= (m_ph == 2); m_ph <= 4; end
              else if (m_ph == 1) begin m_base <= {mem_rsp_data[31:12], 12'h000}; m_ph <= 2; end
              else begin m_ppn <= mem_rsp_data[31:12]; m_perm <= mem_rsp_data[4:1]; m_ph <= 3; end
            end
      default: if (done_ready) m_ph <= 0;
    endcase
  end

  // compare every cycle, then act as memory
  bit       pend = 0;
  int       delay = 0;
  logic [31:0] pend_addr = '0;

  always @(negedge clk) begin
    cycles++;
    if (comparing) begin
      chk("R1 R8 R9 walk_ready", 32'(walk_ready), 32'(m_ph == 0));
      chk("R7 R10 mem_req_valid", 32'(mem_req_valid), 32'((m_ph == 1 || m_ph == 2) && !m_sent));
      if (m_ph == 1 && !m_sent) chk("R2 root address", mem_req_addr, m_root + {20'h0, m_vpn[19:10], 2'b00});
      if (m_ph == 2 && !m_sent) chk("R3 leaf address", mem_req_addr, m_base + {20'h0, m_vpn[9:0], 2'b00});
      chk("R6 R10 fill_valid", 32'(fill_valid), 32'(m_ph == 3));
      chk("R4 R5 R10 fault_valid", 32'(fault_valid), 32'(m_ph == 4));
      if (m_ph >= 3) chk("R6 R9 res_vpn", 32'(res_vpn), 32'(m_vpn));
      if (m_ph == 3) begin
        chk("R6 fill_ppn", 32'(fill_ppn), 32'(m_ppn));
        chk("R6 fill_perm", 32'(fill_perm), 32'(m_perm));
      end
      if (m_ph == 4) chk("R4 R5 fault_lvl", 32'(fault_lvl), 32'(m_lvl));
    end
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    if (pend) begin
      if (delay == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0;
      end else delay--;
    end else if ($urandom % 5 == 0) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;  // stray strobe, R10
    end
    mem_req_ready = ($urandom % 3 != 0);
    if (mem_req_valid && mem_req_ready && !pend && !mem_rsp_valid) begin
      pend = 1; pend_addr = mem_req_addr; delay = $urandom % 4;
    end else if (mem_req_valid && mem_req_ready) mem_req_ready = 1'b0;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic walk(input logic [19:0] vpn, input bit busy_poke, input bit move_root, input int hold);
    @(negedge clk);
    walk_valid = 1'b1; walk_vpn = vpn;
    @(negedge clk);
    if (busy_poke) begin
      walk_vpn = ~vpn;                     // R9: ignored while busy
      repeat (3) @(negedge clk);
    end
    walk_valid = 1'b0;
    if (move_root) root_base = ROOT2;      // R2: sampled at acceptance
    while (!(fill_valid || fault_valid)) @(negedge clk);
    repeat (hold) @(negedge clk);          // R8: result held
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
    root_base = ROOT;
  endtask

  logic [19:0] pool [8];

  initial begin
    mem[ROOT + 3*4]              = pte(20'h20003, 4'h0, 1);
    mem[32'h2000_3000 + 5*4]     = pte(20'hABCDE, 4'b1010, 1);
    mem[32'h2000_3000 + 1023*4]  = 32'h0000_0001;
    mem[ROOT + 7*4]              = 32'hFFFF_FFFE;
    mem[ROOT + 1023*4]           = pte(20'h2FFFF, 4'h0, 1);
    mem[32'h2FFF_F000 + 1023*4]  = pte(20'h12345, 4'b1111, 1);
    mem[ROOT]                    = pte(20'h20000, 4'h0, 1);
    mem[32'h2000_0000]           = pte(20'h00001, 4'b0001, 1);
    mem[ROOT2 + 3*4]             = pte(20'h20000, 4'h0, 1);
    pool = '{ {10'd3,10'd5}, {10'd3,10'd6}, {10'd7,10'd9}, {10'd1023,10'd1023},
              20'h0, {10'd3,10'd1023}, {10'd3,10'd0}, {10'd500,10'd1} };

    repeat (3) @(negedge clk);
    chk("R1 reset walk_ready", 32'(walk_ready), 1);
    chk("R1 reset mem_req_valid", 32'(mem_req_valid), 0);
    chk("R1 reset fill_valid", 32'(fill_valid), 0);
    chk("R1 reset fault_valid", 32'(fault_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    comparing = 1;

    walk({10'd3, 10'd5}, 0, 0, 0);          // R6 refill
    walk({10'd3, 10'd6}, 0, 0, 2);          // R5 leaf absent
    walk({10'd7, 10'd9}, 1, 0, 1);          // R4 root absent, R9
    walk({10'd1023, 10'd1023}, 0, 0, 3);    // R2 R3 top indices
    walk(20'h0, 1, 1, 0);                   // R2 root change mid-walk
    walk({10'd3, 10'd1023}, 0, 0, 0);       // R6 zero flags
    for (int i = 0; i < 60; i++)
      walk(pool[$urandom % 8], bit'($urandom % 2), bit'($urandom % 2), $urandom % 4);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule